// File: doc/BRIEF.md
# Slot-Packed Instruction Prefetch Controller

This unit fetches and sequences instructions for a small stack processor whose instruction words each carry four short opcodes. It keeps the current word in an instruction register and hands one opcode at a time to the execute stage, from the first slot to the last. All instruction fetches and all data accesses share one memory port. On every cycle the unit decides whether that port serves the executing slot or fetches the next word ahead of time.

A word is fetched ahead as soon as no memory-referencing opcode is left in the current word, counting the slot now executing. The fetch then runs in parallel with the remaining register-only slots, so a word with no memory references has no fetch gap at all. A word whose last slot references memory costs one extra fetch cycle after it. A one-word buffer holds the fetched word until the last slot retires. A taken jump, call or return reported by execute drops the rest of the word and any fetched word, and fetching resumes at the target.

Top module: `slot_prefetch_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, `ex_valid` and `ex_fire` are 0. The first memory request is an instruction fetch (`mem_fetch`=1) at address `RESET_ADDR` (default 0).
- R2: A 20-bit word holds slot 0 in bits 19:15, slot 1 in bits 14:10, slot 2 in bits 9:5 and slot 3 in bits 4:0. `ex_op` is the field selected by `ex_slot`, and the slots retire in the order 0, 1, 2, 3.
- R3: An opcode with bit 4 set is a memory opcode. While it is the current slot, the unit drives a data request (`mem_valid`=1, `mem_fetch`=0, `mem_addr`=`ex_addr`), and the slot retires on the cycle `mem_ready` is high. An opcode with bit 4 clear retires in its first cycle.
- R4: No instruction fetch is requested while the current slot or any later slot of the word has bit 4 set.
- R5: Once no memory opcode remains in the word, the fetch of the next sequential word is requested at once, while the remaining slots execute.
- R6: Per word, the memory transactions are the data accesses of its memory slots, in slot order, followed by exactly one fetch of the next word.
- R7: With memory always ready, consecutive words start 4 cycles apart. They start 5 cycles apart when slot 3 of the earlier word is a memory opcode.
- R8: A prefetched word is held until slot 3 retires. It then becomes the current word, starting at slot 0, in the next cycle.
- R9: When `ex_taken` is high as a memory slot retires, the rest of the word and any prefetched word are dropped, and the next transaction is a fetch at `ex_target`.
- R10: `ex_taken` has no effect while a slot without bit 4 retires.
- R11: A request that is not accepted stays asserted in the next cycle with the same `mem_addr` and `mem_fetch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle; read data is valid |
| mem_fetch | output | 1 | 1: instruction fetch, 0: data access for the current slot |
| mem_addr | output | ADDR_W | Request address |
| mem_rdata | input | 20 | Read data, used as the instruction word on fetches |
| ex_valid | output | 1 | `ex_op` holds a live slot |
| ex_op | output | 5 | Opcode of the current slot |
| ex_slot | output | 2 | Index of the current slot |
| ex_fire | output | 1 | The current slot retires this cycle |
| ex_addr | input | ADDR_W | Data address for the current memory slot |
| ex_taken | input | 1 | Control transfer taken by the current slot |
| ex_target | input | ADDR_W | Target word address of a taken transfer |

## Verification
The bench sweeps all sixteen patterns of memory flags across the four slots, first with a memory that is always ready and then with random wait states. It compares every memory transaction against a slot-by-slot reference model. A design that fetched too early would put a fetch ahead of a pending data access. A design that waited for slot 3 before every fetch would show 5-cycle word spacing where 4 is expected. A wrong buffer hand-over would give a mismatched `ex_op` or a skipped word. Jumps are placed to test flushing, and a jump signal raised on a register-only slot must leave the fetch stream unchanged. A design that honoured it would show a fetch of the target address.

// File: rtl/slotfetch_pkg.sv
// Shared constants for the slot-packed fetch unit.
// Assumes: slot 0 sits in the most significant field of a word; SLOTS is a power of two.
package slotfetch_pkg;
    localparam int OP_W      = 5;
    localparam int SLOTS     = 4;
    localparam int MEM_BIT   = 4;
    localparam int WORD_W    = OP_W * SLOTS;
    localparam int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int LAST_SLOT = SLOTS - 1;
endpackage

// File: rtl/sf_pending.sv
// Memory-flag scan for the current word.
// Produces the OR of the memory flags of the current slot and all later slots,
// and the flag of the current slot alone.
// Assumes: word fields are ordered with slot 0 in the top bits.
module sf_pending
    import slotfetch_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [SLOT_W-1:0] slot,
    output logic              pending,
    output logic              cur_mem
);
    logic [SLOTS-1:0] flag;
    logic [SLOTS-1:0] still_ahead;

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_slot
            localparam int FIELD_LSB = WORD_W - (g + 1) * OP_W;
            assign flag[g]        = word[FIELD_LSB + MEM_BIT];
            assign still_ahead[g] = (SLOT_W'(g) >= slot);
        end
    endgenerate

    // Combine flags of the slots that have not yet retired.
    always_comb begin
        pending = |(flag & still_ahead);
        cur_mem = flag[slot];
    end
endmodule

// File: rtl/sf_port_mux.sv
// Single memory port arbiter.
// A memory slot of the current word always wins; otherwise a pending prefetch
// owns the port.
// Assumes: want_fetch is already clear while a memory slot is current.
module sf_port_mux #(
    parameter int ADDR_W = 16
) (
    input  logic              mem_now,
    input  logic              want_fetch,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              mem_valid,
    output logic              mem_fetch,
    output logic [ADDR_W-1:0] mem_addr
);
    // Pick the owner of the port and its address.
    always_comb begin
        mem_valid = mem_now | want_fetch;
        mem_fetch = ~mem_now & want_fetch;
        mem_addr  = mem_now ? data_addr : fetch_addr;
    end
endmodule

// File: rtl/sf_sequencer.sv
// Slot stepping, prefetch buffer and word loading.
// Holds the instruction register, the one-word buffer, the slot counter and
// the next fetch address. A fetch landing while no word is current goes
// straight into the instruction register.
// Assumes: mem_now and pending are derived from ir_q/slot_q by sf_pending.
module sf_sequencer
    import slotfetch_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_now,
    input  logic              pending,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              ex_taken,
    input  logic [ADDR_W-1:0] ex_target,
    output logic [WORD_W-1:0] ir_q,
    output logic              ir_valid_q,
    output logic [SLOT_W-1:0] slot_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic              want_fetch,
    output logic              retire
);
    logic [WORD_W-1:0] buf_q;
    logic              buf_valid_q;
    logic              fetch_done;
    logic              jump;
    logic              last;

    // Decide prefetch, retirement and control transfer for this cycle.
    always_comb begin
        want_fetch = ~buf_valid_q & ~mem_now & (~ir_valid_q | ~pending);
        fetch_done = want_fetch & mem_ready;
        retire     = ir_valid_q & (~mem_now | mem_ready);
        jump       = retire & mem_now & ex_taken;
        last       = (slot_q == SLOT_W'(LAST_SLOT));
    end

    // Advance slot counter, instruction register, buffer and fetch address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q        <= '0;
            ir_valid_q  <= 1'b0;
            buf_q       <= '0;
            buf_valid_q <= 1'b0;
            slot_q      <= '0;
            pc_q        <= RESET_ADDR;
        end else if (jump) begin
            ir_valid_q  <= 1'b0;
            buf_valid_q <= 1'b0;
            slot_q      <= '0;
            pc_q        <= ex_target;
        end else begin
            if (fetch_done) begin
                pc_q <= pc_q + ADDR_W'(1);
            end
            if (retire && last) begin
                slot_q <= '0;
                if (buf_valid_q) begin
                    ir_q        <= buf_q;
                    ir_valid_q  <= 1'b1;
                    buf_valid_q <= 1'b0;
                end else if (fetch_done) begin
                    ir_q       <= mem_rdata;
                    ir_valid_q <= 1'b1;
                end else begin
                    ir_valid_q <= 1'b0;
                end
            end else if (retire) begin
                slot_q <= slot_q + SLOT_W'(1);
                if (fetch_done) begin
                    buf_q       <= mem_rdata;
                    buf_valid_q <= 1'b1;
                end
            end else if (fetch_done) begin
                if (!ir_valid_q) begin
                    ir_q       <= mem_rdata;
                    ir_valid_q <= 1'b1;
                    slot_q     <= '0;
                end else begin
                    buf_q       <= mem_rdata;
                    buf_valid_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/slot_prefetch_ctrl.sv
// Fetch and sequencing unit for a four-slot packed instruction word.
// Steps through the slots, gives the shared memory port to memory slots, and
// prefetches the next word as soon as no memory slot is left in the word.
// Assumes: ex_addr is stable while a memory slot waits for mem_ready.
module slot_prefetch_ctrl
    import slotfetch_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_fetch,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              ex_valid,
    output logic [OP_W-1:0]   ex_op,
    output logic [SLOT_W-1:0] ex_slot,
    output logic              ex_fire,
    input  logic [ADDR_W-1:0] ex_addr,
    input  logic              ex_taken,
    input  logic [ADDR_W-1:0] ex_target
);
    logic [WORD_W-1:0] ir_q;
    logic              ir_valid_q;
    logic [SLOT_W-1:0] slot_q;
    logic [ADDR_W-1:0] pc_q;
    logic              pending;
    logic              cur_mem;
    logic              mem_now;
    logic              want_fetch;
    logic              retire;
    logic [OP_W-1:0]   field [SLOTS];

    sf_pending u_pending (
        .word    (ir_q),
        .slot    (slot_q),
        .pending (pending),
        .cur_mem (cur_mem)
    );

    sf_sequencer #(
        .ADDR_W     (ADDR_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_now    (mem_now),
        .pending    (pending),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .ex_taken   (ex_taken),
        .ex_target  (ex_target),
        .ir_q       (ir_q),
        .ir_valid_q (ir_valid_q),
        .slot_q     (slot_q),
        .pc_q       (pc_q),
        .want_fetch (want_fetch),
        .retire     (retire)
    );

    sf_port_mux #(
        .ADDR_W (ADDR_W)
    ) u_mux (
        .mem_now    (mem_now),
        .want_fetch (want_fetch),
        .data_addr  (ex_addr),
        .fetch_addr (pc_q),
        .mem_valid  (mem_valid),
        .mem_fetch  (mem_fetch),
        .mem_addr   (mem_addr)
    );

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_field
            assign field[g] = ir_q[WORD_W - g * OP_W - 1 -: OP_W];
        end
    endgenerate

    // Present the current slot to execute and qualify the memory flag.
    always_comb begin
        mem_now  = ir_valid_q & cur_mem;
        ex_valid = ir_valid_q;
        ex_op    = field[slot_q];
        ex_slot  = slot_q;
        ex_fire  = retire;
    end
endmodule

// File: rtl/slot_prefetch_ctrl_chk.sv
// Property checker for slot_prefetch_ctrl, attached by bind.
// Recomputes the pending-memory condition from the instruction register on
// its own and checks port protocol and sequencing over time.
module slot_prefetch_ctrl_chk
    import slotfetch_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_fetch,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              ex_valid,
    input logic [OP_W-1:0]   ex_op,
    input logic [SLOT_W-1:0] ex_slot,
    input logic              ex_fire,
    input logic [ADDR_W-1:0] ex_addr,
    input logic              ex_taken,
    input logic [ADDR_W-1:0] ex_target,
    input logic [WORD_W-1:0] ir_word
);
    logic left_mem;

    // Scan the remaining slots of the word for a memory opcode.
    always_comb begin
        left_mem = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (i >= int'(ex_slot)) begin
                left_mem = left_mem | ir_word[WORD_W - i * OP_W - OP_W + MEM_BIT];
            end
        end
    end

    a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_fetch));

    a_r4_no_early_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_fetch && ex_valid |-> !left_mem);

    a_r3_data_port: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && ex_op[MEM_BIT] |-> mem_valid && !mem_fetch && (mem_addr == ex_addr));

    a_r3_quick_retire: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && !ex_op[MEM_BIT] |-> ex_fire);

    a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        ex_fire && (ex_slot != SLOT_W'(LAST_SLOT)) && !(ex_op[MEM_BIT] && ex_taken)
        |=> ex_valid && (ex_slot == $past(ex_slot) + SLOT_W'(1)));

    a_r8_word_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ex_fire && (ex_slot == SLOT_W'(LAST_SLOT)) |=> !ex_valid || (ex_slot == '0));

    a_r9_jump_flush: assert property (@(posedge clk) disable iff (!rst_n)
        ex_fire && ex_op[MEM_BIT] && ex_taken
        |=> !ex_valid && mem_valid && mem_fetch && (mem_addr == $past(ex_target)));
endmodule

bind slot_prefetch_ctrl slot_prefetch_ctrl_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_fetch (mem_fetch),
    .mem_addr  (mem_addr),
    .ex_valid  (ex_valid),
    .ex_op     (ex_op),
    .ex_slot   (ex_slot),
    .ex_fire   (ex_fire),
    .ex_addr   (ex_addr),
    .ex_taken  (ex_taken),
    .ex_target (ex_target),
    .ir_word   (ir_q)
);

// File: tb/slot_prefetch_ctrl_bench.sv
// Bench: sweeps all memory-flag patterns, zero and random wait states, jumps.
module slot_prefetch_ctrl_bench;
    import slotfetch_pkg::*;

    localparam int        AW       = 16;
    localparam logic [4:0] JUMP_OP  = 5'h1A;
    localparam logic [4:0] GHOST_OP = 5'h0A;
    localparam int        MAXT     = 512;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mem_valid, mem_fetch, ex_valid, ex_fire;
    logic              mem_ready = 1'b0;
    logic [AW-1:0]     mem_addr;
    logic [WORD_W-1:0] mem_rdata = '0;
    logic [OP_W-1:0]   ex_op;
    logic [SLOT_W-1:0] ex_slot;
    logic [AW-1:0]     ex_addr = '0;
    logic              ex_taken = 1'b0;
    logic [AW-1:0]     ex_target = '0;

    int total = 0;
    int bad = 0;

    logic          exp_f [MAXT];
    logic [AW-1:0] exp_a [MAXT];
    string         exp_t [MAXT];
    int            exp_n;
    logic [15:0]   lfsr = 16'hACE1;

    always #10 clk = ~clk;

    slot_prefetch_ctrl u_slot_prefetch_ctrl (
        .clk(clk), .rst_n(rst_n),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_fetch(mem_fetch),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .ex_valid(ex_valid), .ex_op(ex_op), .ex_slot(ex_slot), .ex_fire(ex_fire),
        .ex_addr(ex_addr), .ex_taken(ex_taken), .ex_target(ex_target)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, expv);
        end
    endtask

    function automatic logic [OP_W-1:0] prog_op(input logic [AW-1:0] a, input int i, input bit pb);
        logic [OP_W-1:0] op;
        op = {a[SLOTS-1-i], 4'((int'(a) + i) % 8)};
        if (pb && (int'(a) % 5 == 2) && i == 1) op = JUMP_OP;
        if (pb && (int'(a) % 3 == 0) && i == 2) op = GHOST_OP;
        return op;
    endfunction

    function automatic logic [WORD_W-1:0] prog_word(input logic [AW-1:0] a, input bit pb);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int i = 0; i < SLOTS; i++) w[WORD_W - 1 - i * OP_W -: OP_W] = prog_op(a, i, pb);
        return w;
    endfunction

    function automatic logic [AW-1:0] tgt(input int k);
        return AW'(32 + (k * 13) % 200);
    endfunction

    function automatic logic [AW-1:0] daddr(input int s, input logic [OP_W-1:0] op);
        return 16'hD000 | AW'({2'(s), op});
    endfunction

    task automatic push(input logic f, input logic [AW-1:0] a, input string t);
        if (exp_n < MAXT) begin
            exp_f[exp_n] = f; exp_a[exp_n] = a; exp_t[exp_n] = t; exp_n++;
        end
    endtask

    // Reference model: walk the program slot by slot and list the transactions.
    task automatic build(input bit pb, input int limit);
        logic [AW-1:0] pc;
        int jc;
        string ftag;
        pc = '0; jc = 0; exp_n = 0; ftag = "R1";
        while (exp_n < limit) begin
            bit jumped;
            bit ghost;
            push(1'b1, pc, ftag);
            jumped = 0; ghost = 0;
            for (int i = 0; i < SLOTS; i++) begin
                if (!jumped) begin
                    logic [OP_W-1:0] op;
                    op = prog_op(pc, i, pb);
                    if (op[MEM_BIT]) push(1'b0, daddr(i, op), "R3");
                    if (op == JUMP_OP) begin
                        pc = tgt(jc); jc++; jumped = 1;   // R9: rest of word dropped
                    end
                    if (op == GHOST_OP) ghost = 1;      // R10: taken ignored
                end
            end
            if (!jumped) pc = pc + AW'(1);
            ftag = jumped ? "R9" : (ghost ? "R10" : "R5");
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; mem_ready = 1'b0; ex_taken = 1'b0;
        repeat (3) @(negedge clk);
        check(!ex_valid && !ex_fire, "R1", "idle during reset", {ex_valid, ex_fire}, 0);
        rst_n = 1'b1;
        #1;
        check(!ex_valid, "R1", "no slot first cycle", ex_valid, 0);
        check(mem_valid && mem_fetch && mem_addr == '0, "R1", "first fetch",
              {mem_valid, mem_fetch, mem_addr}, {2'b11, 16'h0});
    endtask

    task automatic run_phase(input bit pb, input int dmax);
        int obs, cyc, wait_cnt, jc, words, last_cyc, prev_slot;
        bit waiting;
        logic [AW-1:0] wait_addr, cur_word;
        logic wait_f;
        obs = 0; cyc = 0; wait_cnt = 0; jc = 0; words = 0; last_cyc = 0;
        waiting = 0; wait_addr = '0; wait_f = 0; cur_word = '0; prev_slot = LAST_SLOT;
        while (obs < exp_n && cyc < 20000) begin
            if (cyc > 0) @(negedge clk);
            if (waiting)
                check(mem_valid && mem_addr == wait_addr && mem_fetch == wait_f, "R11",
                      "request held", {mem_fetch, mem_addr}, {wait_f, wait_addr});
            ex_addr   = daddr(int'(ex_slot), ex_op);
            ex_taken  = ex_valid && (ex_op[3:0] == 4'hA);
            ex_target = tgt(jc);
            if (mem_valid && wait_cnt == 0) mem_ready = 1'b1;
            else begin
                mem_ready = 1'b0;
                if (mem_valid) wait_cnt--;
            end
            mem_rdata = prog_word(mem_addr, pb);
            #1;
            waiting = mem_valid && !mem_ready;
            wait_addr = mem_addr; wait_f = mem_fetch;
            if (mem_valid && mem_ready) begin
                check(mem_fetch == exp_f[obs] && mem_addr == exp_a[obs],
                      {exp_t[obs], " R6"}, $sformatf("transaction %0d", obs),
                      {mem_fetch, mem_addr}, {exp_f[obs], exp_a[obs]});
                obs++;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                wait_cnt = (dmax == 0) ? 0 : int'(lfsr) % (dmax + 1);
            end
            if (ex_fire && ex_op == JUMP_OP) jc++;
            if (ex_fire && !pb) begin
                if (ex_slot == '0) begin
                    // R7: word spacing with zero wait states
                    if (words > 0 && words <= 40)
                        check(cyc - last_cyc == 4 + int'(cur_word[0]), "R7", "word spacing",
                              cyc - last_cyc, 4 + int'(cur_word[0]));
                    cur_word = AW'(words); last_cyc = cyc; words++;
                end
                check(int'(ex_slot) == (prev_slot + 1) % SLOTS, "R8", "slot order",
                      ex_slot, (prev_slot + 1) % SLOTS);
                check(ex_op == prog_op(cur_word, int'(ex_slot), 1'b0), "R2", "opcode field",
                      ex_op, prog_op(cur_word, int'(ex_slot), 1'b0));
                prev_slot = int'(ex_slot);
            end
            cyc++;
        end
        check(obs == exp_n, "R6", "all transactions seen (watchdog)", obs, exp_n);
        mem_ready = 1'b0;
    endtask

    initial begin
        build(1'b0, 200);
        do_reset();
        run_phase(1'b0, 0);
        build(1'b1, 400);
        do_reset();
        run_phase(1'b1, 3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule